// File: doc/BRIEF.md
# Prefetch Outcome Tracking Table

This block follows prefetched cache lines from the moment they land in the cache until their fate is known. Each tracked line occupies one slot holding its line address, a valid flag, the tag of the code region that caused the prefetch and the request's position within its prefetch stream. When the line is later touched by a demand access, the block reports the prefetch as useful. When the cache throws the line out untouched, the block reports it as useless. In both cases the slot is freed.

Slots are handed out in strict rotation, oldest first. A new fill that lands on a still-occupied slot pushes the old occupant out, and that occupant is reported as useless. A line that sits unused for too long is therefore treated as a wasted prefetch. Address lookups scan the slots one per cycle. The block raises `busy` while a scan runs, and callers hold their requests until they are accepted. Each outcome leaves as a one-cycle event carrying region, position and a useful flag, ready to feed per-region accuracy counters.

Top module: `pf_outcome_table`

## Requirements
- R1: After reset, `busy` and `evt_vld` are low and every slot is empty, so an eviction notice for any address produces no event.
- R2: An accepted insert completes in one cycle without raising `busy`. Slots are filled in order 0, 1, 2, … and wrap back to 0 after the last slot.
- R3: A demand-use notice whose address matches a valid slot frees that slot and emits an event with `evt_useful`=1 and the slot's stored region and position. A second use of the same address then produces no event.
- R4: An eviction notice whose address matches a valid slot frees that slot and emits an event with `evt_useful`=0 and the slot's stored region and position.
- R5: A use or eviction notice that matches no valid slot produces no event and keeps `busy` high for exactly DEPTH cycles.
- R6: An insert that lands on a still-valid slot emits, in the next cycle, an event with `evt_useful`=0 carrying the displaced entry's region and position.
- R7: A request is accepted only when `busy` is low and no higher-priority request is present. Eviction has priority over use, and use has priority over insert. A request that is not accepted has no effect.
- R8: Requests presented while `busy` is high are ignored. No event appears while `busy` is high.
- R9: A lookup that hits slot k keeps `busy` high for k+1 cycles. Its event appears as a single-cycle pulse in the cycle in which `busy` falls.
- R10: An insert that lands on a slot already freed by use or eviction emits no event.
- R11: When several valid slots hold the same address, a lookup matches the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evict_vld | input | 1 | Cache eviction notice valid |
| evict_addr | input | ADDR_W | Evicted line address |
| use_vld | input | 1 | Demand-use notice valid |
| use_addr | input | ADDR_W | Demand-used line address |
| ins_vld | input | 1 | Prefetch fill insert valid |
| ins_addr | input | ADDR_W | Filled line address |
| ins_region | input | REGION_W | Code region tag of the prefetch |
| ins_pos | input | POS_W | Position of the request in its stream |
| busy | output | 1 | Lookup scan in progress; requests ignored |
| evt_vld | output | 1 | Outcome event pulse |
| evt_region | output | REGION_W | Region tag of the evaluated prefetch |
| evt_pos | output | POS_W | Stream position of the evaluated prefetch |
| evt_useful | output | 1 | 1 = used by demand, 0 = wasted |

## Verification
A corrupted valid bit or a stale rotation pointer shows up at the ports on a later request. A use notice that should hit returns no event, a freed slot reports a displacement, or a displacement carries the wrong region. These errors appear within one insert or one scan of at most DEPTH cycles. A wrong scan index moves the fall of `busy` away from k+1 cycles, so the bench checks hit latency and miss latency as well as event content. Priority errors show as the wrong `evt_useful` value, or as a dropped insert that a later lookup exposes.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic {ST_IDLE, ST_SCAN} pot_state_e;
endpackage

// File: rtl/pot_store.sv
module pot_store #(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 26,
  parameter int REGION_W = 5,
  parameter int POS_W    = 4,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REGION_W-1:0] wr_region,
  input  logic [POS_W-1:0]    wr_pos,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [REGION_W-1:0] rd_region,
  output logic [POS_W-1:0]    rd_pos,
  input  logic [IDX_W-1:0]    vic_idx,
  output logic                vic_valid,
  output logic [REGION_W-1:0] vic_region,
  output logic [POS_W-1:0]    vic_pos
);
  logic [DEPTH-1:0]    vld_q, vld_d;
  logic [ADDR_W-1:0]   addr_q   [DEPTH];
  logic [REGION_W-1:0] region_q [DEPTH];
  logic [POS_W-1:0]    pos_q    [DEPTH];

  // slot valid flags: clear from a lookup hit, set from an insert
  always_comb begin
    vld_d = vld_q;
    if (clr_en) vld_d[clr_idx] = 1'b0;
    if (wr_en)  vld_d[wr_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // payload needs no reset: it is only read behind a set valid bit
  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_q[wr_idx]   <= wr_addr;
      region_q[wr_idx] <= wr_region;
      pos_q[wr_idx]    <= wr_pos;
    end
  end

  assign rd_valid   = vld_q[rd_idx];
  assign rd_addr    = addr_q[rd_idx];
  assign rd_region  = region_q[rd_idx];
  assign rd_pos     = pos_q[rd_idx];
  assign vic_valid  = vld_q[vic_idx];
  assign vic_region = region_q[vic_idx];
  assign vic_pos    = pos_q[vic_idx];
endmodule

// File: rtl/pot_ctrl.sv
module pot_ctrl
  import pot_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 26,
  parameter int REGION_W = 5,
  parameter int POS_W    = 4,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evict_vld,
  input  logic [ADDR_W-1:0]   evict_addr,
  input  logic                use_vld,
  input  logic [ADDR_W-1:0]   use_addr,
  input  logic                ins_vld,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic                clr_en,
  output logic [IDX_W-1:0]    clr_idx,
  output logic [IDX_W-1:0]    rd_idx,
  input  logic                rd_valid,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [REGION_W-1:0] rd_region,
  input  logic [POS_W-1:0]    rd_pos,
  output logic [IDX_W-1:0]    vic_idx,
  input  logic                vic_valid,
  input  logic [REGION_W-1:0] vic_region,
  input  logic [POS_W-1:0]    vic_pos,
  output logic                busy,
  output logic                evt_vld,
  output logic [REGION_W-1:0] evt_region,
  output logic [POS_W-1:0]    evt_pos,
  output logic                evt_useful
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  pot_state_e          st_q, st_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [IDX_W-1:0]    wp_q, wp_d;
  logic [ADDR_W-1:0]   key_q, key_d;
  logic                kind_q, kind_d;   // 1: demand use, 0: eviction
  logic                ev_d;
  logic [REGION_W-1:0] evr_d;
  logic [POS_W-1:0]    evp_d;
  logic                evu_d;
  logic                hit;

  assign hit = rd_valid && (rd_addr == key_q);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    wp_d   = wp_q;
    key_d  = key_q;
    kind_d = kind_q;
    wr_en  = 1'b0;
    clr_en = 1'b0;
    ev_d   = 1'b0;
    evr_d  = rd_region;
    evp_d  = rd_pos;
    evu_d  = kind_q;
    unique case (st_q)
      ST_IDLE: begin
        if (evict_vld) begin
          st_d = ST_SCAN; idx_d = '0; key_d = evict_addr; kind_d = 1'b0;
        end else if (use_vld) begin
          st_d = ST_SCAN; idx_d = '0; key_d = use_addr; kind_d = 1'b1;
        end else if (ins_vld) begin
          wr_en = 1'b1;
          wp_d  = (wp_q == LAST) ? '0 : wp_q + 1'b1;
          if (vic_valid) begin
            ev_d  = 1'b1;
            evr_d = vic_region;
            evp_d = vic_pos;
            evu_d = 1'b0;
          end
        end
      end
      ST_SCAN: begin
        if (hit) begin
          clr_en = 1'b1;
          ev_d   = 1'b1;
          st_d   = ST_IDLE;
        end else if (idx_q == LAST) begin
          st_d = ST_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      wp_q    <= '0;
      evt_vld <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      wp_q    <= wp_d;
      evt_vld <= ev_d;
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_IDLE) begin
      key_q  <= key_d;
      kind_q <= kind_d;
    end
    if (ev_d) begin
      evt_region <= evr_d;
      evt_pos    <= evp_d;
      evt_useful <= evu_d;
    end
  end

  assign wr_idx  = wp_q;
  assign vic_idx = wp_q;
  assign rd_idx  = idx_q;
  assign clr_idx = idx_q;
  assign busy    = (st_q == ST_SCAN);
endmodule

// File: rtl/pf_outcome_table.sv
module pf_outcome_table #(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 26,
  parameter int REGION_W = 5,
  parameter int POS_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evict_vld,
  input  logic [ADDR_W-1:0]   evict_addr,
  input  logic                use_vld,
  input  logic [ADDR_W-1:0]   use_addr,
  input  logic                ins_vld,
  input  logic [ADDR_W-1:0]   ins_addr,
  input  logic [REGION_W-1:0] ins_region,
  input  logic [POS_W-1:0]    ins_pos,
  output logic                busy,
  output logic                evt_vld,
  output logic [REGION_W-1:0] evt_region,
  output logic [POS_W-1:0]    evt_pos,
  output logic                evt_useful
);
  localparam int IDX_W = $clog2(DEPTH);

  logic                wr_en, clr_en, rd_valid, vic_valid;
  logic [IDX_W-1:0]    wr_idx, clr_idx, rd_idx, vic_idx;
  logic [ADDR_W-1:0]   rd_addr;
  logic [REGION_W-1:0] rd_region, vic_region;
  logic [POS_W-1:0]    rd_pos, vic_pos;

  pot_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .REGION_W(REGION_W), .POS_W(POS_W)) u_ctrl (
    .clk, .rst_n, .evict_vld, .evict_addr, .use_vld, .use_addr, .ins_vld,
    .wr_en, .wr_idx, .clr_en, .clr_idx, .rd_idx, .rd_valid, .rd_addr, .rd_region,
    .rd_pos, .vic_idx, .vic_valid, .vic_region, .vic_pos, .busy, .evt_vld,
    .evt_region, .evt_pos, .evt_useful
  );

  pot_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .REGION_W(REGION_W), .POS_W(POS_W)) u_store (
    .clk, .rst_n, .wr_en, .wr_idx, .wr_addr(ins_addr), .wr_region(ins_region),
    .wr_pos(ins_pos), .clr_en, .clr_idx, .rd_idx, .rd_valid, .rd_addr, .rd_region,
    .rd_pos, .vic_idx, .vic_valid, .vic_region, .vic_pos
  );
endmodule

// File: rtl/pf_outcome_table_chk.sv
module pf_outcome_table_chk #(
  parameter int DEPTH = 64
) (
  input logic clk,
  input logic rst_n,
  input logic evict_vld,
  input logic use_vld,
  input logic ins_vld,
  input logic busy,
  input logic evt_vld,
  input logic evt_useful
);
  logic [$clog2(DEPTH+2):0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  // R8: no outcome leaves while a scan is still running
  a_r8_no_event_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vld |-> !busy);

  // R3: a useful outcome can only come from a finished scan
  a_r3_useful_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && evt_useful) |-> $past(busy));

  // R6: an event following an accepted insert is a displacement
  a_r6_displace_useless: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ins_vld && !busy && !evict_vld && !use_vld) && evt_vld) |-> !evt_useful);

  // R7: an accepted lookup starts a scan
  a_r7_lookup_starts_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (evict_vld || use_vld)) |=> busy);

  // R5: a scan never exceeds one pass over the slots
  a_r5_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < DEPTH));

  // R1: control outputs are always known
  a_r1_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({busy, evt_vld}));
endmodule

bind pf_outcome_table pf_outcome_table_chk #(.DEPTH(DEPTH)) u_chk (
  .clk, .rst_n, .evict_vld, .use_vld, .ins_vld, .busy, .evt_vld, .evt_useful
);

// File: tb/tb_pf_outcome_table.sv
module tb_pf_outcome_table;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int RW = 4;
  localparam int PW = 4;

  logic clk, rst_n;
  logic evict_vld, use_vld, ins_vld;
  logic [AW-1:0] evict_addr, use_addr, ins_addr;
  logic [RW-1:0] ins_region;
  logic [PW-1:0] ins_pos;
  logic busy, evt_vld, evt_useful;
  logic [RW-1:0] evt_region;
  logic [PW-1:0] evt_pos;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  pf_outcome_table #(.DEPTH(DEPTH), .ADDR_W(AW), .REGION_W(RW), .POS_W(PW)) dut (
    .clk, .rst_n, .evict_vld, .evict_addr, .use_vld, .use_addr, .ins_vld,
    .ins_addr, .ins_region, .ins_pos, .busy, .evt_vld, .evt_region, .evt_pos,
    .evt_useful
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // op: 1 insert, 2 demand use, 3 eviction
  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [RW-1:0] rg;
    logic [PW-1:0] ps;
    logic          ev;
    logic          uf;
    logic [RW-1:0] erg;
    logic [PW-1:0] eps;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'hA1, 4'd1, 4'd1, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 slot0
    '{2'd1, 8'hA2, 4'd2, 4'd2, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 slot1
    '{2'd2, 8'hA2, 4'd0, 4'd0, 1'b1, 1'b1, 4'd2, 4'd2}, // R3 useful
    '{2'd2, 8'hA2, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 4'd0}, // R3 already freed
    '{2'd3, 8'hA1, 4'd0, 4'd0, 1'b1, 1'b0, 4'd1, 4'd1}, // R4 useless
    '{2'd1, 8'hA3, 4'd3, 4'd3, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 slot2
    '{2'd1, 8'hA4, 4'd4, 4'd4, 1'b0, 1'b0, 4'd0, 4'd0}, // R2 slot3
    '{2'd1, 8'hA5, 4'd5, 4'd5, 1'b0, 1'b0, 4'd0, 4'd0}, // R10 slot0 freed
    '{2'd1, 8'hA6, 4'd6, 4'd6, 1'b0, 1'b0, 4'd0, 4'd0}, // R10 slot1 freed
    '{2'd1, 8'hA7, 4'd7, 4'd7, 1'b1, 1'b0, 4'd3, 4'd3}, // R6 displaces A3
    '{2'd2, 8'hA3, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 4'd0}, // R6 A3 gone
    '{2'd2, 8'hA4, 4'd0, 4'd0, 1'b1, 1'b1, 4'd4, 4'd4}, // R3 slot3
    '{2'd3, 8'h55, 4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 4'd0}  // R5 miss
  };

  logic          g_ev, g_uf;
  logic [RW-1:0] g_rg;
  logic [PW-1:0] g_ps;
  int            g_busy;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    evict_vld = 1'b0; use_vld = 1'b0; ins_vld = 1'b0;
    evict_addr = '0; use_addr = '0; ins_addr = '0; ins_region = '0; ins_pos = '0;
  endtask

  // called at a negedge with inputs already set; gathers the outcome
  task automatic collect();
    g_ev = 1'b0; g_uf = 1'b0; g_rg = '0; g_ps = '0; g_busy = 0;
    @(negedge clk);
    clear_inputs();
    for (int n = 0; n < DEPTH + 4; n++) begin
      if (evt_vld) begin
        g_ev = 1'b1; g_uf = evt_useful; g_rg = evt_region; g_ps = evt_pos;
      end
      if (!busy) break;
      g_busy = g_busy + 1;
      @(negedge clk);
    end
    @(negedge clk);
    check(!evt_vld, "R9", "event lasts one cycle", evt_vld, 0);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [RW-1:0] rg, input logic [PW-1:0] ps);
    case (op)
      2'd1: begin ins_vld = 1'b1; ins_addr = a; ins_region = rg; ins_pos = ps; end
      2'd2: begin use_vld = 1'b1; use_addr = a; end
      default: begin evict_vld = 1'b1; evict_addr = a; end
    endcase
    collect();
  endtask

  task automatic expect_ev(input string req, input logic ev, input logic uf,
                           input logic [RW-1:0] rg, input logic [PW-1:0] ps);
    check(g_ev == ev, req, "event present", g_ev, ev);
    if (ev && g_ev) begin
      check(g_uf == uf, req, "useful flag", g_uf, uf);
      check(g_rg == rg, req, "region", g_rg, rg);
      check(g_ps == ps, req, "position", g_ps, ps);
    end
  endtask

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!evt_vld, "R1", "event after reset", evt_vld, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].op, VECS[i].addr, VECS[i].rg, VECS[i].ps);
      expect_ev($sformatf("vec%0d", i), VECS[i].ev, VECS[i].uf, VECS[i].erg, VECS[i].eps);
      if (VECS[i].op == 2'd1)
        check(g_busy == 0, "R2", "insert busy cycles", g_busy, 0);
    end
    // R5: miss kept busy for DEPTH cycles (last vector)
    check(g_busy == DEPTH, "R5", "miss busy cycles", g_busy, DEPTH);

    // table now: slot0 A5, slot1 A6, slot2 A7, slot3 empty, next slot 3
    // R7: eviction beats use on the same address
    evict_vld = 1'b1; evict_addr = 8'hA5; use_vld = 1'b1; use_addr = 8'hA5;
    collect();
    expect_ev("R7 evict over use", 1'b1, 1'b0, 4'd5, 4'd5);

    // R7: use beats insert; the insert is dropped
    use_vld = 1'b1; use_addr = 8'hA6;
    ins_vld = 1'b1; ins_addr = 8'hA8; ins_region = 4'd8; ins_pos = 4'd8;
    collect();
    expect_ev("R7 use over insert", 1'b1, 1'b1, 4'd6, 4'd6);
    run_op(2'd3, 8'hA8, '0, '0);
    expect_ev("R7 dropped insert absent", 1'b0, 1'b0, '0, '0);

    // R8: eviction offered during a scan is ignored
    use_vld = 1'b1; use_addr = 8'h99;
    @(negedge clk);
    clear_inputs();
    evict_vld = 1'b1; evict_addr = 8'hA7;
    @(negedge clk);
    clear_inputs();
    begin
      int seen = 0;
      for (int n = 0; n < DEPTH + 4; n++) begin
        if (evt_vld) seen = seen + 1;
        if (!busy) break;
        @(negedge clk);
      end
      check(seen == 0, "R8", "events during ignored request", seen, 0);
    end
    @(negedge clk);
    run_op(2'd3, 8'hA7, '0, '0);
    expect_ev("R8 entry still present", 1'b1, 1'b0, 4'd7, 4'd7);

    // R11: duplicates; slots empty, next slot 3
    run_op(2'd1, 8'hD0, 4'd1, 4'd1);  // slot3
    run_op(2'd1, 8'hD0, 4'd2, 4'd2);  // slot0
    run_op(2'd2, 8'hD0, '0, '0);
    expect_ev("R11 lowest slot", 1'b1, 1'b1, 4'd2, 4'd2);
    check(g_busy == 1, "R9", "hit at slot0 busy cycles", g_busy, 1);
    run_op(2'd2, 8'hD0, '0, '0);
    expect_ev("R11 remaining dup", 1'b1, 1'b1, 4'd1, 4'd1);
    check(g_busy == 4, "R9", "hit at slot3 busy cycles", g_busy, 4);

    // R1: reset empties the table
    run_op(2'd1, 8'hE0, 4'd9, 4'd9);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !evt_vld, "R1", "outputs in reset", {busy, evt_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(2'd3, 8'hE0, '0, '0);
    expect_ev("R1 empty after reset", 1'b0, 1'b0, '0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule